// File: doc/BRIEF.md
# Alternate Master Bus Claim Handshake

This block belongs to a device that needs to borrow the system bus from the processor for its own transfers. When local logic asks for a transfer, the block raises a bus request and waits for the processor's grant. A grant on its own is not enough to take the bus. The block first confirms two things:

- The previous master has finished, which shows as the address strobe being negated.
- The previous slave has finished, which shows as both the asynchronous and the synchronous termination acknowledges being negated.

It also waits until no other master is holding the bus acknowledge line.

Once all of that is observed, the block drives its own acknowledge and tells local logic that the bus is owned. It withdraws its request one cycle later. It keeps the acknowledge until local logic reports that the whole transfer is done. Every bus-side input is first passed through a two-flop synchronizer. All signals are active high.

If the grant disappears before the bus has been claimed, the block goes back to requesting and claims nothing. After ownership has been established, losing the grant does not end it. Only the local done flag ends mastership.

Top module: `altmaster_arb`

## Requirements
- R1: While reset is applied, busReq, ackDrive and busOwned are all low.
- R2: From idle, a high startReq makes busReq high after the next clock edge. A grant that arrives while idle with no startReq leaves busReq, ackDrive and busOwned all low.
- R3: After the grant is seen, ackDrive stays low for as long as any one of addrStrobe, asyncAck, syncAck or ackBus is high.
- R4: With the grant held high, ackDrive rises three clock edges after the last of the four busy inputs goes low. This delay is two synchronizer stages plus the state register. busReq is still high in the first cycle in which ackDrive is high.
- R5: busReq falls one cycle after ackDrive rises.
- R6: Once ackDrive is high, it and busOwned stay high until xferDone is seen. A withdrawn grant during ownership has no effect on them.
- R7: A high xferDone while owning makes ackDrive and busOwned low after the next edge. The block then returns to idle with busReq low.
- R8: If the grant goes low before ackDrive rises, the block keeps busReq high and does not raise ackDrive, even when the bus is free. When the grant returns and the bus is free, ackDrive rises four edges later.
- R9: busOwned equals ackDrive in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Local logic asks for the bus (local clock domain) |
| xferDone | input | 1 | Local logic has finished all its bus cycles |
| busGrant | input | 1 | Grant from the processor (asynchronous) |
| addrStrobe | input | 1 | Address strobe seen on the bus (asynchronous) |
| asyncAck | input | 1 | Asynchronous slave termination, any size (asynchronous) |
| syncAck | input | 1 | Synchronous slave termination (asynchronous) |
| ackBus | input | 1 | Bus acknowledge line as seen on the bus (asynchronous) |
| busReq | output | 1 | Bus request to the processor |
| ackDrive | output | 1 | Drive for the bus acknowledge line |
| busOwned | output | 1 | Tells local logic the bus is held |

## Verification
The hardest situation to reach is a grant that is already present while the bus is still busy. In that case each busy condition has to hold off the claim on its own. The stimulus sets all four busy inputs high before the request. It then releases them one at a time, with a full synchronizer delay between each release, so that every single one is shown to block ackDrive. A second case withdraws the grant while the block is waiting for the bus to become free. It then clears the bus while the grant is absent, to show that the block does not claim the bus on its own, before the grant returns.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int SYNC_STAGES = 2;
  localparam int BUS_INPUTS  = 5;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_WAIT = 3'd2,
    ST_OWN  = 3'd3,
    ST_REL  = 3'd4
  } arbState_t;

  typedef struct packed {
    logic markFirst;
    logic clearFirst;
  } ctrlStrobes_t;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else if (g == 0) stage[g] <= din;
        else stage[g] <= stage[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         busGrant,
  input  logic         addrStrobe,
  input  logic         asyncAck,
  input  logic         syncAck,
  input  logic         ackBus,
  input  ctrlStrobes_t strobes,
  output logic         grantS,
  output logic         busFree,
  output logic         firstOwn
);
  localparam int BUSY_BITS = BUS_INPUTS - 1;

  logic [BUS_INPUTS-1:0] rawIn;
  logic [BUS_INPUTS-1:0] syncIn;
  logic [BUSY_BITS-1:0]  busyS;

  assign rawIn = {busGrant, ackBus, syncAck, asyncAck, addrStrobe};

  arb_sync #(.WIDTH(BUS_INPUTS), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawIn),
    .dout (syncIn)
  );

  assign busyS   = syncIn[BUSY_BITS-1:0];
  assign grantS  = syncIn[BUS_INPUTS-1];
  assign busFree = ~|busyS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) firstOwn <= 1'b0;
    else if (strobes.markFirst) firstOwn <= 1'b1;
    else if (strobes.clearFirst) firstOwn <= 1'b0;
  end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         xferDone,
  input  logic         grantS,
  input  logic         busFree,
  input  logic         firstOwn,
  output ctrlStrobes_t strobes,
  output logic         busReq,
  output logic         ackDrive,
  output logic         busOwned
);
  arbState_t state, stateNext;

  always_comb begin
    stateNext          = state;
    strobes.markFirst  = 1'b0;
    strobes.clearFirst = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq) stateNext = ST_REQ;
      ST_REQ:  if (grantS) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (!grantS) stateNext = ST_REQ;
        else if (busFree) begin
          stateNext         = ST_OWN;
          strobes.markFirst = 1'b1;
        end
      end
      ST_OWN: begin
        strobes.clearFirst = 1'b1;
        if (xferDone) stateNext = ST_REL;
      end
      ST_REL:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign busReq   = (state == ST_REQ) || (state == ST_WAIT) ||
                    ((state == ST_OWN) && firstOwn);
  assign ackDrive = (state == ST_OWN);
  assign busOwned = (state == ST_OWN);

  p_claim_free_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> $past(busFree));
  p_claim_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> $past(grantS));
  p_req_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq) |=> busReq);
  p_req_overlap_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> busReq);
  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |=> !busReq);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackDrive && !xferDone) |=> ackDrive);
  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackDrive && xferDone) |=> (!ackDrive && !busOwned));
endmodule

// File: rtl/altmaster_arb.sv
module altmaster_arb
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic xferDone,
  input  logic busGrant,
  input  logic addrStrobe,
  input  logic asyncAck,
  input  logic syncAck,
  input  logic ackBus,
  output logic busReq,
  output logic ackDrive,
  output logic busOwned
);
  ctrlStrobes_t strobes;
  logic grantS, busFree, firstOwn;

  arb_datapath uDp (
    .clk        (clk),
    .rstN       (rstN),
    .busGrant   (busGrant),
    .addrStrobe (addrStrobe),
    .asyncAck   (asyncAck),
    .syncAck    (syncAck),
    .ackBus     (ackBus),
    .strobes    (strobes),
    .grantS     (grantS),
    .busFree    (busFree),
    .firstOwn   (firstOwn)
  );

  arb_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .xferDone (xferDone),
    .grantS   (grantS),
    .busFree  (busFree),
    .firstOwn (firstOwn),
    .strobes  (strobes),
    .busReq   (busReq),
    .ackDrive (ackDrive),
    .busOwned (busOwned)
  );
endmodule

// File: tb/sim_altmaster_arb.sv
module sim_altmaster_arb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 0, xferDone = 0, busGrant = 0;
  logic addrStrobe = 0, asyncAck = 0, syncAck = 0, ackBus = 0;
  logic busReq, ackDrive, busOwned;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    int    at;
    logic  r, a, o;
    string tag;
  } expItem_t;
  expItem_t q[$];

  altmaster_arb u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .xferDone(xferDone),
    .busGrant(busGrant), .addrStrobe(addrStrobe), .asyncAck(asyncAck),
    .syncAck(syncAck), .ackBus(ackBus), .busReq(busReq),
    .ackDrive(ackDrive), .busOwned(busOwned)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(string tag, logic r, logic a, logic o);
    total++;
    if (busReq !== r || ackDrive !== a || busOwned !== o || busOwned !== ackDrive) begin
      bad++;
      $display("FAIL %s cyc=%0d req/ack/own actual=%b%b%b expected=%b%b%b",
               tag, cyc, busReq, ackDrive, busOwned, r, a, o);
    end
  endtask

  task automatic expectAt(int k, logic r, logic a, logic o, string tag);
    expItem_t it;
    it.at = cyc + k; it.r = r; it.a = a; it.o = o; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic stepN(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      expItem_t it;
      it = q.pop_front();
      compare(it.tag, it.r, it.a, it.o);
    end
  end

  initial begin
    stepN(5000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    addrStrobe = 1; asyncAck = 1; syncAck = 1; ackBus = 1;
    stepN(3);
    compare("R1", 0, 0, 0);
    rstN = 1;
    stepN(2);

    // Scenario: grant present while bus is busy; release one by one
    startReq = 1; expectAt(1, 1, 0, 0, "R2"); stepN(1);
    startReq = 0;
    busGrant = 1; expectAt(3, 1, 0, 0, "R3"); expectAt(6, 1, 0, 0, "R3"); stepN(6);
    addrStrobe = 0; expectAt(4, 1, 0, 0, "R3"); stepN(4);
    asyncAck = 0;   expectAt(4, 1, 0, 0, "R3"); stepN(4);
    syncAck = 0;    expectAt(4, 1, 0, 0, "R3"); stepN(4);
    ackBus = 0;
    expectAt(2, 1, 0, 0, "R4");
    expectAt(3, 1, 1, 1, "R4");
    expectAt(4, 0, 1, 1, "R5");
    stepN(4);
    busGrant = 0; expectAt(8, 0, 1, 1, "R6"); stepN(8);
    xferDone = 1; expectAt(1, 0, 0, 0, "R7"); stepN(1);
    xferDone = 0; expectAt(1, 0, 0, 0, "R7"); expectAt(4, 0, 0, 0, "R7"); stepN(4);

    // Grant while idle without a start request is ignored
    busGrant = 1; expectAt(5, 0, 0, 0, "R2"); stepN(5);
    busGrant = 0; stepN(3);

    // Grant withdrawn while waiting for a free bus
    addrStrobe = 1; stepN(3);
    startReq = 1; expectAt(1, 1, 0, 0, "R2"); stepN(1);
    startReq = 0;
    busGrant = 1; expectAt(4, 1, 0, 0, "R3"); stepN(4);
    busGrant = 0; expectAt(4, 1, 0, 0, "R8"); stepN(4);
    addrStrobe = 0; expectAt(5, 1, 0, 0, "R8"); stepN(5);
    busGrant = 1;
    expectAt(3, 1, 0, 0, "R8");
    expectAt(4, 1, 1, 1, "R8");
    expectAt(5, 0, 1, 1, "R5");
    stepN(5);
    xferDone = 1; expectAt(1, 0, 0, 0, "R7"); stepN(1);
    xferDone = 0; busGrant = 0; expectAt(2, 0, 0, 0, "R9"); stepN(3);

    while (q.size() > 0) stepN(1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule